// File: doc/BRIEF.md
# Dual-Clock Stream FIFO with Fill Reporting

This block moves a valid/ready data stream from a source clock domain into an unrelated destination clock domain. Words are stored in a power-of-two array. The write and read pointers each carry one extra wrap bit. Each pointer is handed to the opposite domain as a gray code, and a chain of flip-flops in the receiving domain catches it. The source side sees a free-entry count, called `room`. The destination side sees a stored-entry count, called `level`. Each count is computed only from values local to its own clock domain, so it is conservative: it may lag the far side by the synchronizer latency.

The parameter `OUT_REG` selects an optional registered output stage, which is a two-state machine:
- `OS_EMPTY` means the stage holds no word.
- `OS_FULL` means it holds one word that is presented on `out_data`.

The transitions are:
- **load**: `OS_EMPTY` to `OS_FULL`, when the array has a word.
- **refill**: `OS_FULL` to `OS_FULL`, when the consumer takes the held word and the array has another.
- **drain**: `OS_FULL` to `OS_EMPTY`, when the consumer takes the held word and the array is empty.
- **hold**: `OS_FULL` to `OS_FULL`, when `out_ready` is low.
- **idle**: `OS_EMPTY` to `OS_EMPTY`, when the array is empty.

The held word is not counted in `level`.

Each domain has its own active-high synchronous reset. Both resets must be applied together before use.

Top module: `dc_stream_fifo`

## Requirements
- R1: `room` is DEPTH minus the number of entries the write domain believes are stored. `room` never exceeds DEPTH and reads DEPTH after reset. Once the read side has been idle long enough for the pointers to cross, `room` equals DEPTH minus the words held in the array.
- R2: `in_ready` is low exactly when `room` is zero.
- R3: A write offered while `in_ready` is low has no effect. The write pointer does not move, and no stored word is replaced.
- R4: Words leave on `out_data` in the order they were accepted, with no loss and no duplication.
- R5: `level` never exceeds DEPTH. With `OUT_REG`=0 and the write side idle long enough, `level` equals the number of stored words.
- R6: With `OUT_REG`=0, `out_valid` is high exactly when `level` is non-zero.
- R7: With `OUT_REG`=1, a presented word stays valid and unchanged until it is taken. When idle, `level` equals the stored words minus the one held in the output stage.
- R8: The gray-coded write pointer changes by at most one bit per write clock.
- R9: While reset is asserted in both domains, `in_ready`=1, `out_valid`=0, `room`=DEPTH and `level`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Source-domain clock |
| wr_rst | input | 1 | Source-domain synchronous reset, active high |
| in_valid | input | 1 | Source offers a word |
| in_ready | output | 1 | FIFO can accept a word |
| in_data | input | DATA_W | Word offered by the source |
| room | output | ADDR_W+1 | Free entries seen from the source domain |
| rd_clk | input | 1 | Destination-domain clock |
| rd_rst | input | 1 | Destination-domain synchronous reset, active high |
| out_valid | output | 1 | A word is presented |
| out_ready | input | 1 | Destination takes the presented word |
| out_data | output | DATA_W | Presented word |
| level | output | ADDR_W+1 | Stored entries seen from the destination domain |

## Verification
The properties assume that both resets are asserted together from time zero, each for several cycles of its own clock. They also assume that the source and destination handshake inputs change only away from the active edges. The bench drives every input on a falling edge and holds both resets for several cycles of the slower clock. It uses unrelated clock periods, so pointer crossings happen at shifting phase offsets. Exact values of `room` and `level` are checked only after the opposite side has been idle for many more cycles than the synchronizer depth.

// File: rtl/dsf_pkg.sv
package dsf_pkg;
    typedef enum logic {
        OS_EMPTY = 1'b0,
        OS_FULL  = 1'b1
    } ostage_e;
endpackage

// File: rtl/dsf_ptr.sv
// Binary pointer with a registered gray copy for crossing.
module dsf_ptr #(
    parameter int PW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          inc,
    output logic [PW-1:0] bin,
    output logic [PW-1:0] gray
);
    logic [PW-1:0] bin_nx;

    always_comb bin_nx = bin + PW'(inc);

    always_ff @(posedge clk) begin
        if (rst) begin
            bin  <= '0;
            gray <= '0;
        end else begin
            bin  <= bin_nx;
            gray <= bin_nx ^ (bin_nx >> 1);
        end
    end
endmodule

// File: rtl/dsf_sync.sv
// Multi-stage capture of a gray pointer plus conversion back to binary.
module dsf_sync #(
    parameter int PW     = 4,
    parameter int STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [PW-1:0] gray_in,
    output logic [PW-1:0] gray_out,
    output logic [PW-1:0] bin_out
);
    logic [PW-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= '0;
        else     stg[0] <= gray_in;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg[s] <= '0;
            else     stg[s] <= stg[s-1];
        end
    end

    assign gray_out = stg[STAGES-1];

    always_comb begin
        bin_out[PW-1] = gray_out[PW-1];
        for (int i = PW - 2; i >= 0; i--) begin
            bin_out[i] = bin_out[i+1] ^ gray_out[i];
        end
    end
endmodule

// File: rtl/dsf_mem.sv
// Storage array: written in the source domain, read combinationally.
module dsf_mem #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 3
) (
    input  logic              wclk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/dsf_out_stage.sv
// Optional registered output stage: a two-state holder.
module dsf_out_stage
    import dsf_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fifo_has,
    input  logic [DATA_W-1:0] fifo_data,
    output logic              pop,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);
    ostage_e state, state_nx;
    logic    take;

    always_comb begin
        take     = 1'b0;
        state_nx = state;
        unique case (state)
            OS_EMPTY: begin
                if (fifo_has) begin
                    take     = 1'b1;
                    state_nx = OS_FULL;
                end
            end
            OS_FULL: begin
                if (out_ready) begin
                    take     = fifo_has;
                    state_nx = fifo_has ? OS_FULL : OS_EMPTY;
                end
            end
            default: state_nx = OS_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= OS_EMPTY;
        else     state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (take) out_data <= fifo_data;
    end

    always_comb begin
        pop       = take;
        out_valid = (state == OS_FULL);
    end
endmodule

// File: rtl/dc_stream_fifo.sv
module dc_stream_fifo #(
    parameter int DATA_W      = 8,
    parameter int ADDR_W      = 3,
    parameter int SYNC_STAGES = 2,
    parameter bit OUT_REG     = 1'b0
) (
    input  logic              wr_clk,
    input  logic              wr_rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    output logic [ADDR_W:0]   room,
    input  logic              rd_clk,
    input  logic              rd_rst,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic [ADDR_W:0]   level
);
    localparam int            PW      = ADDR_W + 1;
    localparam int            DEPTH   = 1 << ADDR_W;
    localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

    logic [PW-1:0]     wbin, wgray, rbin, rgray;
    logic [PW-1:0]     rgray_w, rbin_w, wgray_r, wbin_r;
    logic              wr_fire, full, empty, fifo_pop;
    logic [DATA_W-1:0] rd_word;

    // ---------------- source domain ----------------
    assign wr_fire = in_valid & in_ready;

    dsf_ptr #(.PW(PW)) u_wptr (
        .clk(wr_clk), .rst(wr_rst), .inc(wr_fire), .bin(wbin), .gray(wgray)
    );

    dsf_sync #(.PW(PW), .STAGES(SYNC_STAGES)) u_rsync (
        .clk(wr_clk), .rst(wr_rst), .gray_in(rgray),
        .gray_out(rgray_w), .bin_out(rbin_w)
    );

    // Full when the gray pointers differ only in the top two bits.
    assign full     = (wgray == {~rgray_w[PW-1:PW-2], rgray_w[PW-3:0]});
    assign in_ready = ~full;
    assign room     = DEPTH_P - (wbin - rbin_w);

    dsf_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
        .wclk(wr_clk), .we(wr_fire), .waddr(wbin[ADDR_W-1:0]), .wdata(in_data),
        .raddr(rbin[ADDR_W-1:0]), .rdata(rd_word)
    );

    // ---------------- destination domain ----------------
    dsf_sync #(.PW(PW), .STAGES(SYNC_STAGES)) u_wsync (
        .clk(rd_clk), .rst(rd_rst), .gray_in(wgray),
        .gray_out(wgray_r), .bin_out(wbin_r)
    );

    assign empty = (rgray == wgray_r);
    assign level = wbin_r - rbin;

    dsf_ptr #(.PW(PW)) u_rptr (
        .clk(rd_clk), .rst(rd_rst), .inc(fifo_pop), .bin(rbin), .gray(rgray)
    );

    if (OUT_REG) begin : g_oreg
        dsf_out_stage #(.DATA_W(DATA_W)) u_ostage (
            .clk(rd_clk), .rst(rd_rst), .fifo_has(~empty), .fifo_data(rd_word),
            .pop(fifo_pop), .out_ready(out_ready), .out_valid(out_valid),
            .out_data(out_data)
        );
    end else begin : g_direct
        assign out_valid = ~empty;
        assign out_data  = rd_word;
        assign fifo_pop  = out_valid & out_ready;
    end
endmodule

// File: rtl/dc_stream_fifo_chk.sv
module dc_stream_fifo_chk #(
    parameter int DATA_W  = 8,
    parameter int ADDR_W  = 3,
    parameter bit OUT_REG = 1'b0
) (
    input logic              wr_clk,
    input logic              wr_rst,
    input logic              in_ready,
    input logic [ADDR_W:0]   room,
    input logic [ADDR_W:0]   wgray,
    input logic [ADDR_W:0]   wbin,
    input logic              rd_clk,
    input logic              rd_rst,
    input logic              out_valid,
    input logic              out_ready,
    input logic [DATA_W-1:0] out_data,
    input logic [ADDR_W:0]   level
);
    localparam logic [ADDR_W:0] DEPTH_P = (ADDR_W + 1)'(1 << ADDR_W);

    // R1
    room_bound_chk: assert property (@(posedge wr_clk) disable iff (wr_rst)
        room <= DEPTH_P);

    // R2
    ready_room_chk: assert property (@(posedge wr_clk) disable iff (wr_rst)
        in_ready == (room != '0));

    // R3
    blocked_write_chk: assert property (@(posedge wr_clk) disable iff (wr_rst)
        !in_ready |=> wbin == $past(wbin));

    // R8
    gray_step_chk: assert property (@(posedge wr_clk) disable iff (wr_rst)
        $countones(wgray ^ $past(wgray)) <= 1);

    // R5
    level_bound_chk: assert property (@(posedge rd_clk) disable iff (rd_rst)
        level <= DEPTH_P);

    if (OUT_REG) begin : g_reg_chk
        // R7
        held_word_chk: assert property (@(posedge rd_clk) disable iff (rd_rst)
            (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
    end else begin : g_dir_chk
        // R6
        valid_level_chk: assert property (@(posedge rd_clk) disable iff (rd_rst)
            out_valid == (level != '0));
    end
endmodule

bind dc_stream_fifo dc_stream_fifo_chk #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .OUT_REG(OUT_REG)
) u_chk (
    .wr_clk(wr_clk), .wr_rst(wr_rst), .in_ready(in_ready), .room(room),
    .wgray(wgray), .wbin(wbin), .rd_clk(rd_clk), .rd_rst(rd_rst),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .level(level)
);

// File: tb/tb_dc_stream_fifo.sv
module tb_dc_stream_fifo;
    localparam int WR_PERIOD = 10;
    localparam int RD_PERIOD = 14;
    localparam int DW = 8;
    localparam int AW = 3;
    localparam int DEPTH = 1 << AW;

    logic          wr_clk = 0, rd_clk = 0, wr_rst = 1, rd_rst = 1;
    logic          in_valid = 0, out_ready = 0;
    logic [DW-1:0] in_data = '0;
    logic          in_ready, out_valid, in_ready_r, out_valid_r;
    logic [DW-1:0] out_data, out_data_r;
    logic [AW:0]   room, level, room_r, level_r;

    int     vectors = 0, fails = 0;
    int     rd_mode = 0;   // 0 hold off, 1 always take, 2 random
    int     rd_density = 2;
    bit     finished = 0;
    logic [DW-1:0] q0[$], q1[$];
    logic [DW-1:0] seq = '0;

    always #(WR_PERIOD/2) wr_clk = ~wr_clk;
    always #(RD_PERIOD/2) rd_clk = ~rd_clk;

    dc_stream_fifo #(.DATA_W(DW), .ADDR_W(AW), .OUT_REG(1'b0)) dut (
        .wr_clk(wr_clk), .wr_rst(wr_rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .room(room), .rd_clk(rd_clk), .rd_rst(rd_rst),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .level(level)
    );

    dc_stream_fifo #(.DATA_W(DW), .ADDR_W(AW), .OUT_REG(1'b1)) dut_reg (
        .wr_clk(wr_clk), .wr_rst(wr_rst), .in_valid(in_valid), .in_ready(in_ready_r),
        .in_data(in_data), .room(room_r), .rd_clk(rd_clk), .rd_rst(rd_rst),
        .out_valid(out_valid_r), .out_ready(out_ready), .out_data(out_data_r),
        .level(level_r)
    );

    task automatic check(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    // Drive one write-clock cycle; record accepted words before the edge.
    task automatic wr_cycle(input bit v);
        @(negedge wr_clk);
        in_valid = v;
        in_data  = seq;
        seq      = seq + 1'b1;
        #1;
        if (in_valid && in_ready)   q0.push_back(in_data);
        if (in_valid && in_ready_r) q1.push_back(in_data);
    endtask

    task automatic idle_wr(input int n);
        for (int i = 0; i < n; i++) wr_cycle(1'b0);
    endtask

    // Read-side driver and order checker (R4, R3 no overwrite).
    initial begin
        forever begin
            @(negedge rd_clk);
            case (rd_mode)
                0:       out_ready = 1'b0;
                1:       out_ready = 1'b1;
                default: out_ready = (($urandom % 4) < rd_density);
            endcase
            #1;
            if (out_valid && out_ready) begin
                if (q0.size() == 0) check("R4 unexpected word", int'(out_data), -1);
                else check("R4 order", int'(out_data), int'(q0.pop_front()));
            end
            if (out_valid_r && out_ready) begin
                if (q1.size() == 0) check("R4 unexpected word reg", int'(out_data_r), -1);
                else check("R4 order reg", int'(out_data_r), int'(q1.pop_front()));
            end
        end
    end

    task automatic settle_checks(input string tag);
        int held;
        rd_mode = 0;
        idle_wr(30);
        held = out_valid_r ? 1 : 0;
        check({"R5 level exact ", tag}, int'(level), q0.size());
        check({"R1 room ", tag}, int'(room), DEPTH - q0.size());
        check({"R2 ready ", tag}, int'(in_ready), (q0.size() != DEPTH) ? 1 : 0);
        check({"R6 valid ", tag}, int'(out_valid), (q0.size() != 0) ? 1 : 0);
        check({"R7 level minus held ", tag}, int'(level_r), q1.size() - held);
        check({"R7 held when stored ", tag}, held, (q1.size() != 0) ? 1 : 0);
        check({"R1 room reg ", tag}, int'(room_r), DEPTH - (q1.size() - held));
    endtask

    initial begin
        repeat (6) @(negedge rd_clk);
        // R9: reset values while both resets are held
        check("R9 in_ready", int'(in_ready), 1);
        check("R9 out_valid", int'(out_valid), 0);
        check("R9 room", int'(room), DEPTH);
        check("R9 level", int'(level), 0);
        check("R9 out_valid reg", int'(out_valid_r), 0);
        @(negedge wr_clk); wr_rst = 0;
        @(negedge rd_clk); rd_rst = 0;
        idle_wr(4);
        check("R1 room after reset", int'(room), DEPTH);

        // Fill past full with the reader stalled (R2, R3, R5, R7)
        rd_mode = 0;
        for (int i = 0; i < 30; i++) wr_cycle(1'b1);
        check("R3 accepted count", q0.size(), DEPTH);
        check("R3 accepted count reg", q1.size(), DEPTH + 1);
        settle_checks("full");
        check("R2 ready low full", int'(in_ready), 0);
        check("R2 ready low full reg", int'(in_ready_r), 0);

        // Drain everything (R4)
        rd_mode = 1;
        idle_wr(60);
        settle_checks("drained");
        check("R4 all delivered", q0.size() + q1.size(), 0);

        // Sweep write and read densities
        for (int wd = 0; wd < 4; wd++) begin
            for (int rdn = 0; rdn < 4; rdn++) begin
                rd_density = rdn + 1;
                rd_mode    = 2;
                for (int i = 0; i < 50; i++) wr_cycle(($urandom % 4) <= wd);
                settle_checks("sweep");
            end
        end

        rd_mode = 1;
        idle_wr(80);
        settle_checks("final");
        finished = 1;
        summary();
    end

    initial begin
        repeat (150000) @(posedge wr_clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual hung expected done");
            summary();
        end
    end
endmodule